// File: doc/BRIEF.md
# Table-Driven Multi-Class Colour Classifier

This block labels every pixel of a video stream with the set of colour classes it belongs to. Each pixel arrives as a 3-bit intensity value and two 6-bit chroma values (U and V). Instead of dividing chroma by intensity and comparing against per-class bounds, the block uses two small lookup memories. One is indexed by intensity and U, the other by intensity and V. Each word holds one membership bit per class, so every class is tested in the same read. The division-free test for a class, intensity above a floor with `Y*Umin < U < Y*Umax` and `Y*Vmin < V < Y*Vmax`, is folded into the table contents offline.

Before streaming starts, a host writes both tables through a simple load port. During streaming the block returns an N-bit class vector one cycle after each pixel. The pixel valid and sync flags are delayed by the same cycle, so downstream logic sees them aligned with the class vector.

Top module: `colour_class_lut`

## Requirements
- R1: The U table (written with `wr_sel_i` = 0) is read at address `{pix_y_i, pix_u_i}`, where intensity forms the upper 3 bits.
- R2: The V table (written with `wr_sel_i` = 1) is read at address `{pix_y_i, pix_v_i}`, where intensity forms the upper 3 bits.
- R3: Bit c of `class_o` is the AND of bit c of the U-table word and bit c of the V-table word. Bit c stands for colour class c.
- R4: `class_o`, `valid_o` and `sync_o` for a pixel appear exactly one clock cycle after that pixel is presented.
- R5: `class_o` is all zeros in any cycle where `valid_o` is low.
- R6: A pixel presented while `load_en_i` is high yields an all-zero `class_o`, while its `valid_o` and `sync_o` still follow.
- R7: A write to one table leaves every word of the other table unchanged.
- R8: While `rst_ni` is low, `valid_o` and `sync_o` are low and `class_o` is zero.
- R9: `wr_en_i` may be high only while `load_en_i` is high.
- R10: A word written in one cycle is returned by a read of the same address issued in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_en_i | input | 1 | Table loading in progress |
| wr_en_i | input | 1 | Table write strobe |
| wr_sel_i | input | 1 | Table select: 0 = U table, 1 = V table |
| wr_addr_i | input | 9 | Write address {intensity, chroma} |
| wr_data_i | input | N_CLASS | One membership bit per class |
| pix_valid_i | input | 1 | Pixel valid |
| pix_sync_i | input | 1 | Pixel sync flag |
| pix_y_i | input | 3 | Pixel intensity |
| pix_u_i | input | 6 | Pixel U chroma |
| pix_v_i | input | 6 | Pixel V chroma |
| class_o | output | N_CLASS | Class membership vector |
| valid_o | output | 1 | Aligned valid |
| sync_o | output | 1 | Aligned sync |

## Verification
Corrupted table words, swapped address fields or a wrong table select show up at `class_o` on the very next cycle after the affected pixel. A sweep over every intensity, U and V combination therefore exposes such faults at once. A missing or extra pipeline stage shows as `valid_o` or `sync_o` sliding against the class vector, which is visible on the first pixel of a burst. Loss of the load-time blanking appears in the first cycle after a pixel is fed during loading.

// File: rtl/colour_class_pkg.sv
package colour_class_pkg;
  localparam int unsigned Y_W    = 3;
  localparam int unsigned C_W    = 6;
  localparam int unsigned ADDR_W = Y_W + C_W;

  typedef enum logic {
    TBL_U = 1'b0,
    TBL_V = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/class_table.sv
module class_table #(
  parameter int unsigned W      = 4,
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [W-1:0]      rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  // read-before-write on a same-address collision
  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

  assert_write_visible_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == raddr_i) ##1 (raddr_i == $past(raddr_i) && !we_i)
    |=> rdata_o == $past(wdata_i, 2));
endmodule

// File: rtl/class_sideband.sv
module class_sideband (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic sync_i,
  input  logic blank_i,
  output logic valid_o,
  output logic sync_o,
  output logic blank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sync_o  <= 1'b0;
      blank_o <= 1'b1;
    end else begin
      valid_o <= valid_i;
      sync_o  <= sync_i;
      blank_o <= blank_i;
    end
  end

  assert_valid_delay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_sync_delay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> sync_o);
endmodule

// File: rtl/colour_class_lut.sv
module colour_class_lut
  import colour_class_pkg::*;
#(
  parameter int unsigned N_CLASS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_en_i,
  input  logic               wr_en_i,
  input  logic               wr_sel_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [N_CLASS-1:0] wr_data_i,
  input  logic               pix_valid_i,
  input  logic               pix_sync_i,
  input  logic [Y_W-1:0]     pix_y_i,
  input  logic [C_W-1:0]     pix_u_i,
  input  logic [C_W-1:0]     pix_v_i,
  output logic [N_CLASS-1:0] class_o,
  output logic               valid_o,
  output logic               sync_o
);
  localparam int unsigned N_TBL = 2;

  logic [N_CLASS-1:0] tbl_q [N_TBL];
  logic               blank_q;

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    localparam tbl_sel_e SEL = (t == 0) ? TBL_U : TBL_V;
    logic [C_W-1:0]    chroma;
    logic [ADDR_W-1:0] raddr;
    assign chroma = (SEL == TBL_U) ? pix_u_i : pix_v_i;
    assign raddr  = {pix_y_i, chroma};

    class_table #(.W(N_CLASS), .ADDR_W(ADDR_W)) u_table (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && (wr_sel_i == SEL)),
      .waddr_i (wr_addr_i),
      .wdata_i (wr_data_i),
      .raddr_i (raddr),
      .rdata_o (tbl_q[t])
    );
  end

  class_sideband u_side (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (pix_valid_i),
    .sync_i  (pix_sync_i),
    .blank_i (load_en_i || !pix_valid_i),
    .valid_o (valid_o),
    .sync_o  (sync_o),
    .blank_o (blank_q)
  );

  assign class_o = blank_q ? '0 : (tbl_q[0] & tbl_q[1]);

  assert_write_in_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> load_en_i);
  assert_load_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |=> class_o == '0);
  assert_idle_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> class_o == '0);
  assert_reset_idle_R8: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !sync_o && class_o == '0));
endmodule

// File: tb/colour_class_lut_test.sv
module colour_class_lut_test;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [8:0]    wr_addr = '0;
  logic [NC-1:0] wr_data = '0;
  logic          pv = 1'b0, ps = 1'b0;
  logic [2:0]    py = '0;
  logic [5:0]    pu = '0, pvv = '0;
  logic [NC-1:0] cls;
  logic          vo, so;

  int tests = 0, fails = 0;
  int ymin [NC], umin [NC], umax [NC], vmin [NC], vmax [NC];

  always #2 clk = ~clk;

  colour_class_lut #(.N_CLASS(NC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .load_en_i(load_en), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pix_valid_i(pv), .pix_sync_i(ps), .pix_y_i(py), .pix_u_i(pu),
    .pix_v_i(pvv), .class_o(cls), .valid_o(vo), .sync_o(so));

  function automatic int sgn6(input int x);
    return (x >= 32) ? x - 64 : x;
  endfunction

  function automatic logic [NC-1:0] hit(input bit is_v, input int y, input int c6);
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) begin
      int s = sgn6(c6);
      int lo = is_v ? vmin[c] : umin[c];
      int hi = is_v ? vmax[c] : umax[c];
      r[c] = (y > ymin[c]) && (y * lo < s) && (s < y * hi);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [NC-1:0] ec,
                       input logic ev, input logic es);
    tests++;
    if (cls !== ec || vo !== ev || so !== es) begin
      fails++;
      $display("FAIL %s: class=%h valid=%b sync=%b expected class=%h valid=%b sync=%b",
               req, cls, vo, so, ec, ev, es);
    end
  endtask

  task automatic wr(input bit sel, input int a, input logic [NC-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_addr = a[8:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      ymin[c] = $urandom_range(3, 0);
      umin[c] = $urandom_range(4, 0) - 4;
      umax[c] = $urandom_range(4, 0);
      vmin[c] = $urandom_range(4, 0) - 4;
      vmax[c] = $urandom_range(4, 0);
    end
    // R8: reset state
    pv = 1'b1; ps = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", '0, 1'b0, 1'b0);
    pv = 1'b0; ps = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: load both tables with load_en high; R1 U table, R2 V table
    load_en = 1'b1;
    for (int a = 0; a < 512; a++) wr(1'b0, a, hit(1'b0, a >> 6, a & 63));
    for (int a = 0; a < 512; a++) wr(1'b1, a, hit(1'b1, a >> 6, a & 63));

    // R6: pixels presented during loading are blanked
    for (int k = 0; k < 4; k++) begin
      pv = 1'b1; ps = (k == 1); py = 3'd7; pu = 6'd1; pvv = 6'd1;
      @(negedge clk);
      check("R6", '0, 1'b1, (k == 1));
    end
    pv = 1'b0; ps = 1'b0;
    load_en = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R4 R5: exhaustive sweep
    begin
      logic [NC-1:0] e_c;
      logic e_v, e_s, have;
      have = 1'b0; e_c = '0; e_v = 1'b0; e_s = 1'b0;
      for (int y = 0; y < 8; y++)
        for (int u = 0; u < 64; u++)
          for (int v = 0; v < 64; v++) begin
            logic nv;
            nv = ((u + v + y) % 7) != 0;
            py = y[2:0]; pu = u[5:0]; pvv = v[5:0];
            pv = nv; ps = (u == 0 && v == 0);
            @(negedge clk);
            check(nv ? "R3" : "R5", nv ? (hit(1'b0, y, u) & hit(1'b1, y, v)) : '0,
                  nv, (u == 0 && v == 0));
            have = 1'b1;
          end
      pv = 1'b0; ps = 1'b0;
      @(negedge clk);
      check("R4", '0, 1'b0, 1'b0);
    end

    // R7 R10: overwrite one V word with all ones, U table untouched
    load_en = 1'b1;
    wr(1'b1, {3'd5, 6'd9}, '1);
    load_en = 1'b0;
    for (int u = 0; u < 64; u++) begin
      py = 3'd5; pu = u[5:0]; pvv = 6'd9; pv = 1'b1; ps = 1'b0;
      @(negedge clk);
      check("R7", hit(1'b0, 5, u), 1'b1, 1'b0);
    end
    // V word reads back as written: U word all ones pairs with new V word
    load_en = 1'b1;
    wr(1'b0, {3'd2, 6'd3}, '1);
    wr(1'b1, {3'd2, 6'd4}, 4'b1010);
    load_en = 1'b0;
    py = 3'd2; pu = 6'd3; pvv = 6'd4; pv = 1'b1;
    @(negedge clk);
    check("R10", 4'b1010, 1'b1, 1'b0);
    pv = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule